// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block merges four reset requests into one synchronous core reset and decides how long the core stays in reset once every request has gone away. The requests are power-on (which also resets this block), low supply voltage, an active-low external reset pin and watchdog overflow. A loss of power or voltage stops the system oscillator. After such a loss the block counts a long settling interval before it lets the core run. A pin or watchdog reset leaves the oscillator running and restarts the core after a short interval.

The block keeps a four-bit register of reset causes that software reads and clears. Each cause sets its own flag. A flag is cleared only by writing a zero to its bit. Resets that are not power-on leave the other flags in place, so software can see what happened since it last cleared them. When the core leaves reset, the block raises a one-cycle request to fetch the start address from the vector at the top of program space.

The clock `clk` is assumed to be an always-on reference. Oscillator clocks are counted on it after the oscillator enable returns.

Top module: `rstseq_top`

## Requirements
- R1: While `por_n` is low at a clock edge, the next cycle shows `sys_rst`=1 and `osc_en`=0, and `rd_data` reads 0x01. All flags are cleared except the power-on flag (bit 0).
- R2: After `por_n` goes high, `sys_rst` stays high for 4096 cycles after the first edge that sees it high, and `osc_en` stays high throughout that wait.
- R3: An edge that samples `lvr_req`=1 gives `sys_rst`=1, `osc_en`=0 and flag bit 2 set in the next cycle. Once the request drops, the restart wait is 4096 cycles.
- R4: An edge that samples `wdt_ovf`=1 gives `sys_rst`=1 and flag bit 3 set, and `osc_en` stays 1. Once the request drops, the restart wait is 2 cycles. `osc_en` is always 1 while `sys_rst` is 0.
- R5: `ext_rst_n` passes through a two-flop synchronizer and is honoured only while `pin_rst_en`=1. It then sets flag bit 1 and uses the 2-cycle restart. While `pin_rst_en`=0 it causes no reset and changes no flag.
- R6: A write with `wr_en`=1 clears each flag whose `wr_data` bit (3:0) is 0 and leaves the flags whose bit is 1. `wr_data[7:4]` is ignored, and `rd_data[7:4]` always reads 0.
- R7: If a cause is active in the same cycle as a write that clears its flag, the flag ends up set.
- R8: Low-voltage, pin and watchdog resets never clear a flag. Without a write, flags only accumulate.
- R9: Simultaneous causes set every matching flag. The long wait applies if low voltage is among them.
- R10: `vec_fetch` is a single-cycle pulse in the first cycle with `sys_rst`=0, and `vec_addr` is then 0x1FFE.
- R11: A request that arrives during the restart wait returns the block to hold. The wait restarts when the request drops, and it stays long if a long wait was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| por_n | input | 1 | Power-on request, active low, sampled synchronously; also resets the block |
| lvr_req | input | 1 | Low-voltage reset request, active high |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| pin_rst_en | input | 1 | Configuration: honour the external reset pin |
| wdt_ovf | input | 1 | Watchdog overflow reset request, active high |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 8 | Write data; a 0 in bits 3:0 clears that flag |
| rd_data | output | 8 | Flag register: bit3 watchdog, bit2 low voltage, bit1 pin, bit0 power-on |
| sys_rst | output | 1 | Synchronous core reset, active high |
| osc_en | output | 1 | System oscillator enable |
| vec_fetch | output | 1 | One-cycle request to fetch the reset vector |
| vec_addr | output | 13 | Address of the reset vector |

## Verification
Two things can land in the same cycle: a software write that clears the flags, and a new cause that sets one of them. The bench raises the watchdog request and a write of all zeros on the same clock edge, then expects only the watchdog flag to remain set. It also lets requests overlap the restart wait, including a short request inside a pending long wait, and judges each case by counting the cycles from the request drop to the vector fetch pulse.

// File: rtl/rstseq_pkg.sv
// Shared types for the reset sequencer.
// Assumes: flag bit positions are visible to software and must not move.
package rstseq_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_st_t;

    localparam int FLG_POR = 0;
    localparam int FLG_PIN = 1;
    localparam int FLG_LVR = 2;
    localparam int FLG_WDT = 3;
    localparam int NFLAG   = 4;
endpackage

// File: rtl/rstseq_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; rst_n is synchronous and active low; output settles to RST_VAL.
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_flags.sv
// Reset-cause flag register: set by causes, cleared per bit by writing zero.
// Assumes: por_n clears all flags except the power-on flag, which it sets;
// a set in the same cycle as a clearing write wins.
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic [NFLAG-1:0] set_vec,
    input  logic             wr_en,
    input  logic [NFLAG-1:0] keep_mask,
    output logic [NFLAG-1:0] flags
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic bit_q;

        // One sticky flag bit with write-zero-to-clear.
        always_ff @(posedge clk) begin
            if (!por_n)                    bit_q <= (i == FLG_POR);
            else if (set_vec[i])           bit_q <= 1'b1;
            else if (wr_en && !keep_mask[i]) bit_q <= 1'b0;
        end

        assign flags[i] = bit_q;
    end
endmodule

// File: rtl/rstseq_timer.sv
// Hold / restart-wait / run sequencer with a cause-dependent delay.
// Assumes: requests are synchronous levels; a long request or power-on
// makes the pending wait long until the core runs again.
module rstseq_timer
    import rstseq_pkg::*;
#(
    parameter int LONG_CYC  = 4096,
    parameter int SHORT_CYC = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic long_req,
    input  logic short_req,
    output logic sys_rst,
    output logic osc_en,
    output logic vec_fetch
);
    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);

    seq_st_t       st;
    logic          long_q;
    logic [CW-1:0] cnt;
    logic          vec_q;

    // Sequence state, pending delay class and restart counter.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            st     <= ST_HOLD;
            long_q <= 1'b1;
            cnt    <= '0;
            vec_q  <= 1'b0;
        end else begin
            vec_q <= 1'b0;
            if (long_req || short_req) begin
                st     <= ST_HOLD;
                long_q <= long_q | long_req;
            end else begin
                case (st)
                    ST_HOLD: begin
                        st  <= ST_WAIT;
                        cnt <= long_q ? LONG_LD : SHORT_LD;
                    end
                    ST_WAIT: begin
                        if (cnt == '0) begin
                            st     <= ST_RUN;
                            vec_q  <= 1'b1;
                            long_q <= 1'b0;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_RUN:  st <= ST_RUN;
                    default: st <= ST_HOLD;
                endcase
            end
        end
    end

    // Decode outputs from the registered state.
    always_comb begin
        sys_rst   = (st != ST_RUN);
        osc_en    = !((st == ST_HOLD) && long_q);
        vec_fetch = vec_q;
    end
endmodule

// File: rtl/rstseq_top.sv
// Reset sequencer top: merges four reset causes, times the restart,
// keeps software-clearable cause flags and requests the reset vector.
// Assumes: por_n is the synchronous block reset; ext_rst_n is asynchronous.
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int          DATA_W      = 8,
    parameter int          ADDR_W      = 13,
    parameter logic [12:0] VEC_ADDR    = 13'h1FFE,
    parameter int          LONG_CYC    = 4096,
    parameter int          SHORT_CYC   = 2,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              lvr_req,
    input  logic              ext_rst_n,
    input  logic              pin_rst_en,
    input  logic              wdt_ovf,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sys_rst,
    output logic              osc_en,
    output logic              vec_fetch,
    output logic [ADDR_W-1:0] vec_addr
);
    logic             pin_sync_n;
    logic             pin_act;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flags;

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (ext_rst_n),
        .q     (pin_sync_n)
    );

    // Qualify the synchronized pin and collect flag set requests.
    always_comb begin
        pin_act          = pin_rst_en && !pin_sync_n;
        set_vec          = '0;
        set_vec[FLG_PIN] = pin_act;
        set_vec[FLG_LVR] = lvr_req;
        set_vec[FLG_WDT] = wdt_ovf;
    end

    rstseq_flags u_flags (
        .clk       (clk),
        .por_n     (por_n),
        .set_vec   (set_vec),
        .wr_en     (wr_en),
        .keep_mask (wr_data[NFLAG-1:0]),
        .flags     (flags)
    );

    rstseq_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
        .clk       (clk),
        .por_n     (por_n),
        .long_req  (lvr_req),
        .short_req (pin_act || wdt_ovf),
        .sys_rst   (sys_rst),
        .osc_en    (osc_en),
        .vec_fetch (vec_fetch)
    );

    assign rd_data  = {{(DATA_W-NFLAG){1'b0}}, flags};
    assign vec_addr = ADDR_W'(VEC_ADDR);
endmodule

// File: rtl/rstseq_chk.sv
// Assertion checker for rstseq_top, attached by bind.
// Assumes: default widths (8-bit data, 13-bit vector address).
module rstseq_chk #(
    parameter logic [12:0] VEC_ADDR = 13'h1FFE
) (
    input logic        clk,
    input logic        por_n,
    input logic        lvr_req,
    input logic        wdt_ovf,
    input logic        wr_en,
    input logic [7:0]  rd_data,
    input logic        sys_rst,
    input logic        osc_en,
    input logic        vec_fetch,
    input logic [12:0] vec_addr
);
    logic seen = 1'b0;

    // Mark that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) seen <= 1'b1;

    assert_por_state_R1: assert property (@(posedge clk)
        (seen && $past(!por_n)) |-> (sys_rst && !osc_en && rd_data == 8'h01));

    assert_lvr_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
        ($past(lvr_req) && $past(por_n)) |-> (sys_rst && !osc_en && rd_data[2]));

    // Set wins over a same-cycle clearing write (R7), watchdog holds reset (R4).
    assert_wdt_flag_R7: assert property (@(posedge clk) disable iff (!por_n)
        ($past(wdt_ovf) && $past(por_n)) |-> (sys_rst && rd_data[3]));

    assert_osc_running_R4: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst |-> osc_en);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
        ($past(por_n) && !$past(wr_en)) |-> ((rd_data & $past(rd_data)) == $past(rd_data)));

    assert_vec_pulse_R10: assert property (@(posedge clk) disable iff (!por_n)
        vec_fetch |-> (!sys_rst && $past(sys_rst) && vec_addr == VEC_ADDR));

    assert_vec_single_R10: assert property (@(posedge clk) disable iff (!por_n)
        vec_fetch |=> !vec_fetch);
endmodule

bind rstseq_top rstseq_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .lvr_req   (lvr_req),
    .wdt_ovf   (wdt_ovf),
    .wr_en     (wr_en),
    .rd_data   (rd_data),
    .sys_rst   (sys_rst),
    .osc_en    (osc_en),
    .vec_fetch (vec_fetch),
    .vec_addr  (vec_addr)
);

// File: tb/tb_rstseq_top.sv
`timescale 1ns/1ps
module tb_rstseq_top;
    localparam int LONG  = 4096;
    localparam int SHORT = 2;

    logic        clk = 1'b0;
    logic        por_n, lvr_req, ext_rst_n, pin_rst_en, wdt_ovf, wr_en;
    logic [7:0]  wr_data, rd_data;
    logic        sys_rst, osc_en, vec_fetch;
    logic [12:0] vec_addr;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [3:0]  mflags = 4'b0;

    always #2 clk = ~clk;

    rstseq_top dut (
        .clk(clk), .por_n(por_n), .lvr_req(lvr_req), .ext_rst_n(ext_rst_n),
        .pin_rst_en(pin_rst_en), .wdt_ovf(wdt_ovf), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .sys_rst(sys_rst),
        .osc_en(osc_en), .vec_fetch(vec_fetch), .vec_addr(vec_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected flag register after a write (R6).
    function automatic logic [3:0] after_write(input logic [3:0] f, input logic [7:0] d);
        return f & d[3:0];
    endfunction

    // Count negedges after a request drop until the vector fetch pulse.
    task automatic finish_run(input int exp_cyc, input string tag);
        int c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!vec_fetch && c < 6000);
        chk(c == exp_cyc, tag, c, exp_cyc);
        chk(!sys_rst && vec_addr == 13'h1FFE, "R10 vector request at release",
            {sys_rst, vec_addr}, 13'h1FFE);
        @(negedge clk);
        chk(!vec_fetch, "R10 vector request is one cycle", vec_fetch, 0);
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mflags = after_write(mflags, d);
        chk(rd_data == {4'b0, mflags}, "R6 write-zero clears flag", rd_data, {4'b0, mflags});
    endtask

    task automatic episode(input bit l, input bit w, input bit e, input bit en, input int hold);
        bit eff = e && en;
        bit any = l || w || eff;
        lvr_req = l; wdt_ovf = w; ext_rst_n = !e; pin_rst_en = en;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            if (!any) chk(!sys_rst, "R5 disabled pin causes no reset", sys_rst, 0);
        end
        if (l || w)
            chk(sys_rst && (osc_en == !l), "R3 R4 hold and oscillator", {sys_rst, osc_en}, {1'b1, !l});
        lvr_req = 1'b0; wdt_ovf = 1'b0; ext_rst_n = 1'b1;
        mflags = mflags | {w, l, eff, 1'b0};
        if (any)
            finish_run((l ? LONG : SHORT) + 1 + (eff ? 2 : 0),
                       (l && (w || eff)) ? "R9 mixed causes take long wait" :
                       l ? "R3 long restart" : eff ? "R5 pin restart via synchronizer" :
                       "R4 watchdog short restart");
        else
            @(negedge clk);
        chk(rd_data == {4'b0, mflags}, "R8 flags accumulate, R9 all set", rd_data, {4'b0, mflags});
    endtask

    task automatic por_pulse();
        int c = 0;
        bit osc_bad = 0;
        por_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(sys_rst && !osc_en && rd_data == 8'h01, "R1 power-on state",
            {sys_rst, osc_en, rd_data}, {1'b1, 1'b0, 8'h01});
        por_n = 1'b1;
        mflags = 4'b0001;
        do begin
            @(negedge clk);
            c++;
            if (!osc_en && !vec_fetch) osc_bad = 1;
        end while (!vec_fetch && c < 6000);
        chk(c == LONG + 1, "R2 power-on settling wait", c, LONG + 1);
        chk(!osc_bad, "R2 oscillator on during wait", osc_bad, 0);
        @(negedge clk);
        chk(rd_data == 8'h01, "R1 only power-on flag after power-on", rd_data, 8'h01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed0;
        seed0 = $urandom(32'd20250611);
        por_n = 1'b0; lvr_req = 1'b0; ext_rst_n = 1'b1; pin_rst_en = 1'b0;
        wdt_ovf = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        @(negedge clk);
        por_pulse();

        // R6: upper bits ignored, ones keep, zeros clear
        episode(0, 1, 0, 0, 2);
        do_write(8'hFF);
        do_write(8'hF7);
        chk(rd_data[7:4] == 4'h0, "R6 upper bits read zero", rd_data[7:4], 0);

        // R5: disabled pin is ignored, enabled pin resets
        episode(0, 0, 1, 0, 4);
        episode(0, 0, 1, 1, 1);

        // R7: set and clearing write in one cycle
        wdt_ovf = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wdt_ovf = 1'b0; wr_en = 1'b0;
        mflags = 4'b1000;
        chk(rd_data == 8'h08, "R7 set wins over clearing write", rd_data, 8'h08);
        finish_run(SHORT + 1, "R7 watchdog restart after write");

        // R11: request inside the restart wait
        wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
        @(negedge clk);
        wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
        finish_run(SHORT + 1, "R11 short wait restarts");
        lvr_req = 1'b1; @(negedge clk); lvr_req = 1'b0;
        repeat (5) @(negedge clk);
        wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
        finish_run(LONG + 1, "R11 pending long wait stays long");
        mflags = mflags | 4'b1100;

        // R9: all causes at once
        episode(1, 1, 1, 1, 3);

        do_write(8'h00);
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 3 == 0) do_write(8'($urandom));
            episode(($urandom % 5) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
                    1 + int'($urandom % 4));
        end

        // R8: only power-on clears the other flags
        episode(0, 1, 0, 0, 1);
        por_pulse();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule